// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDR SDRAM device from power-up to normal operation without help from software. After reset it holds the clock enable low for one cycle and then raises it. It keeps the command bus idle for a pause of at least 200 microseconds, counted in clock cycles from a clock-frequency parameter. It then issues a precharge of every bank, eight auto-refresh commands and a mode-register load. It waits the required gap after each of these commands before it moves on.

The settings come in as static configuration inputs: geometry codes, CAS latency, burst-length code, precharge and refresh-cycle gaps in clocks, the data-width select and the refresh period. When the sequence is complete, the block raises `init_done`, which stays high until reset. It also starts a periodic timer that pulses `refresh_req` so that later logic can schedule refreshes. A combinational output gives the device capacity as the base-2 logarithm of its byte count.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `cke` is 0, the command `{cs_n,ras_n,cas_n,we_n}` is NOP (4'b0111), `addr` and `ba` are 0, and `init_done` and `refresh_req` are 0.
- R2: After reset is released, `cke` is 1 and the command is NOP for exactly CLK_MHZ*PAUSE_US cycles. No command other than NOP appears while `cke` is 0.
- R3: After the pause comes one Precharge All cycle (4'b0010, `addr` bit 10 set, every other address bit 0). It is followed by max(`cfg_trp`,1) NOP cycles.
- R4: Exactly eight auto-refresh cycles (4'b0001, `addr` 0) follow. Each one is followed by max(`cfg_trc`,1) NOP cycles, and any non-NOP command is followed by a NOP.
- R5: Next comes one Load Mode cycle (4'b0000) with `ba` 0, `addr[2:0]` = `cfg_burst`, `addr[3]` = 0, `addr[6:4]` = `cfg_cas` and the upper bits 0. It is followed by exactly 2 NOP cycles.
- R6: Then `init_done` goes to 1 and stays at 1 until reset, and the command stays NOP.
- R7: With P = `cfg_refresh_period` (P >= 2), `refresh_req` is a one-cycle pulse that first appears P cycles after the cycle in which `init_done` rises, then again every P cycles. It never appears while `init_done` is 0.
- R8: `size_log2` equals (`cfg_col_code`+8) + (`cfg_row_code`+11) + (`cfg_bank_code`+1) + 1, plus one more when `cfg_wide` is 1 (32-bit width) rather than 0 (16-bit).
- R9: Once `cke` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_col_code | input | 2 | Column address bits minus 8 |
| cfg_row_code | input | 2 | Row address bits minus 11 |
| cfg_bank_code | input | 1 | Bank address bits minus 1 |
| cfg_cas | input | 3 | CAS latency written to the mode register |
| cfg_burst | input | 3 | Burst-length code written to the mode register |
| cfg_trp | input | T_W | Precharge gap in clocks |
| cfg_trc | input | T_W | Refresh-cycle gap in clocks |
| cfg_wide | input | 1 | 1 = 32-bit data, 0 = 16-bit data |
| cfg_refresh_period | input | REFP_W | Clocks between refresh requests |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | SDRAM address bus |
| ba | output | 2 | Bank address |
| init_done | output | 1 | Sequence complete, sticky until reset |
| refresh_req | output | 1 | One-cycle periodic refresh request |
| size_log2 | output | 6 | log2 of device size in bytes |

## Verification
The whole command timeline is checked cycle by cycle against a timeline that the bench builds from the configuration. Randomly drawn gap lengths move every later command by a different amount, so an off-by-one in either gap or in the refresh count shows up as a shifted or missing command. Zero-valued gaps test the one-cycle minimum. Varied CAS and burst codes show the mode word carrying its fields in the right bit positions. Refresh periods from 2 upward show the difference between a correct first pulse and one that comes a cycle early or late. Random geometry codes with both width settings test the size sum.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;
    typedef enum logic [2:0] {
        ST_CKE, ST_PAUSE, ST_PRE, ST_REF, ST_MRS, ST_WAIT, ST_NORMAL
    } seq_state_e;

    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

    localparam int REF_COUNT = 8;
    localparam int MRD_CYCLES = 2;
    localparam int REF_W = $clog2(REF_COUNT) + 1;

    typedef struct packed {
        seq_state_e         state;
        seq_state_e         ret;
        logic [REF_W-1:0]   ref_cnt;
        logic               cke;
    } seq_regs_t;
endpackage

// File: rtl/sdram_delay_cnt.sv
module sdram_delay_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] period,
    output logic          req
);
    logic [PW-1:0] cnt_d, cnt_q, reload;
    logic          req_d, req_q;

    always_comb begin
        reload = (period == '0) ? '0 : period - 1'b1;
        req_d  = en && (cnt_q == '0);
        if (!en)
            cnt_d = reload;
        else if (cnt_q == '0)
            cnt_d = reload;
        else
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            req_q <= req_d;
        end
    end

    assign req = req_q;
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_pwrup_pkg::*;
#(
    parameter int CLK_MHZ  = 50,
    parameter int PAUSE_US = 200,
    parameter int ADDR_W   = 13,
    parameter int T_W      = 4,
    parameter int REFP_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_col_code,
    input  logic [1:0]        cfg_row_code,
    input  logic              cfg_bank_code,
    input  logic [2:0]        cfg_cas,
    input  logic [2:0]        cfg_burst,
    input  logic [T_W-1:0]    cfg_trp,
    input  logic [T_W-1:0]    cfg_trc,
    input  logic              cfg_wide,
    input  logic [REFP_W-1:0] cfg_refresh_period,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba,
    output logic              init_done,
    output logic              refresh_req,
    output logic [5:0]        size_log2
);
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int CNT_W     = $clog2(PAUSE_CYC + 1);

    seq_regs_t        q, d;
    logic             dly_load, dly_zero;
    logic [CNT_W-1:0] dly_val;
    logic [3:0]       cmd;

    function automatic logic [CNT_W-1:0] gap_load(input logic [T_W-1:0] t);
        return (t == '0) ? '0 : CNT_W'(t - 1'b1);
    endfunction

    always_comb begin
        d        = q;
        dly_load = 1'b0;
        dly_val  = '0;
        unique case (q.state)
            ST_CKE: begin
                d.cke    = 1'b1;
                d.state  = ST_PAUSE;
                dly_load = 1'b1;
                dly_val  = CNT_W'(PAUSE_CYC - 1);
            end
            ST_PAUSE: if (dly_zero) d.state = ST_PRE;
            ST_PRE: begin
                d.state  = ST_WAIT;
                d.ret    = ST_REF;
                dly_load = 1'b1;
                dly_val  = gap_load(cfg_trp);
            end
            ST_REF: begin
                d.ref_cnt = q.ref_cnt + 1'b1;
                d.state   = ST_WAIT;
                d.ret     = (q.ref_cnt == REF_W'(REF_COUNT - 1)) ? ST_MRS : ST_REF;
                dly_load  = 1'b1;
                dly_val   = gap_load(cfg_trc);
            end
            ST_MRS: begin
                d.state  = ST_WAIT;
                d.ret    = ST_NORMAL;
                dly_load = 1'b1;
                dly_val  = CNT_W'(MRD_CYCLES - 1);
            end
            ST_WAIT: if (dly_zero) d.state = q.ret;
            default: d.state = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_CKE;
            q.ret     <= ST_CKE;
            q.ref_cnt <= '0;
            q.cke     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    sdram_delay_cnt #(.W(CNT_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .zero     (dly_zero)
    );

    sdram_refresh_timer #(.PW(REFP_W)) u_rtmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (init_done),
        .period (cfg_refresh_period),
        .req    (refresh_req)
    );

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        unique case (q.state)
            ST_PRE: begin
                cmd      = CMD_PRE;
                addr[10] = 1'b1;
            end
            ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd       = CMD_MRS;
                addr[2:0] = cfg_burst;
                addr[6:4] = cfg_cas;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign ba        = 2'b00;
    assign cke       = q.cke;
    assign init_done = (q.state == ST_NORMAL);
    assign size_log2 = 6'(cfg_col_code) + 6'(cfg_row_code) + 6'(cfg_bank_code)
                     + 6'd21 + (cfg_wide ? 6'd1 : 6'd0);
endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
    parameter int ADDR_W = 13,
    parameter int REFP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done,
    input logic              refresh_req,
    input logic [2:0]        cfg_cas,
    input logic [2:0]        cfg_burst,
    input logic [REFP_W-1:0] cfg_refresh_period
);
    logic [3:0] cmd;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    AST_NO_CMD_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd == 4'b0111);                                              // R2
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0010 |-> addr[10]);                                          // R3
    AST_GAP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 4'b0111 |=> cmd == 4'b0111);                                    // R4
    AST_MRS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0000 |-> (addr[6:4] == cfg_cas && addr[2:0] == cfg_burst));  // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);                                              // R6
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cmd == 4'b0111);                                         // R6
    AST_REQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> init_done);                                            // R7
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && cfg_refresh_period > 1) |=> !refresh_req);             // R7
    AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);                                                          // R9
endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(.ADDR_W(ADDR_W), .REFP_W(REFP_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .cke                (cke),
    .cs_n               (cs_n),
    .ras_n              (ras_n),
    .cas_n              (cas_n),
    .we_n               (we_n),
    .addr               (addr),
    .init_done          (init_done),
    .refresh_req        (refresh_req),
    .cfg_cas            (cfg_cas),
    .cfg_burst          (cfg_burst),
    .cfg_refresh_period (cfg_refresh_period)
);

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;
    localparam int CLK_MHZ = 50, PAUSE_US = 200, ADDR_W = 13, T_W = 4, REFP_W = 16;
    localparam int PC = CLK_MHZ * PAUSE_US;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_col_code = '0, cfg_row_code = '0;
    logic cfg_bank_code = 1'b0, cfg_wide = 1'b0;
    logic [2:0] cfg_cas = 3'd2, cfg_burst = '0;
    logic [T_W-1:0] cfg_trp = 4'd1, cfg_trc = 4'd1;
    logic [REFP_W-1:0] cfg_refresh_period = 16'd4;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
    logic [ADDR_W-1:0] addr;
    logic [1:0] ba;
    logic [5:0] size_log2;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdram_pwrup_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .ADDR_W(ADDR_W),
                      .T_W(T_W), .REFP_W(REFP_W)) dut (.*);

    function automatic int gap(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int exp_size(input int c, r, b, w);
        return (c + 8) + (r + 11) + (b + 1) + (w ? 2 : 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // n cycles of one expected command, address and done flag
    task automatic seg(input logic [3:0] ec, input int n, input logic [ADDR_W-1:0] ea,
                       input string tag);
        bit ok = 1'b1;
        int act = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ok && ({cs_n, ras_n, cas_n, we_n} != ec || addr != ea || ba != 2'b00 ||
                       cke !== 1'b1 || init_done !== 1'b0 || refresh_req !== 1'b0)) begin
                ok = 1'b0;
                act = {cke, cs_n, ras_n, cas_n, we_n, 13'(addr)};
            end
        end
        chk(ok, tag, act, {1'b1, ec, ea});
    endtask

    task automatic run(input int trp, trc, cas, bl, c, r, b, w, per);
        int t;
        bit ok;
        cfg_trp = T_W'(trp); cfg_trc = T_W'(trc); cfg_cas = 3'(cas); cfg_burst = 3'(bl);
        cfg_col_code = 2'(c); cfg_row_code = 2'(r); cfg_bank_code = 1'(b);
        cfg_wide = 1'(w); cfg_refresh_period = REFP_W'(per);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cke == 1'b0 && {cs_n, ras_n, cas_n, we_n} == NOP && addr == '0 && ba == 2'b00 &&
            !init_done && !refresh_req, "R1 reset state",
            {cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req}, 7'b0011100);
        chk(size_log2 == 6'(exp_size(c, r, b, w)), "R8 size", size_log2, exp_size(c, r, b, w));
        rst_n = 1'b1;
        seg(NOP, PC, '0, "R2 pause");
        seg(PRE, 1, ADDR_W'(1 << 10), "R3 precharge");
        seg(NOP, gap(trp), '0, "R3 tRP gap");
        for (int k = 0; k < 8; k++) begin
            seg(REF, 1, '0, "R4 refresh");
            seg(NOP, gap(trc), '0, "R4 tRC gap");
        end
        seg(MRS, 1, ADDR_W'((cas << 4) | bl), "R5 load mode");
        seg(NOP, 2, '0, "R5 tMRD gap");
        ok = 1'b1; t = -1;
        for (int k = 0; k <= 2 * per + 1; k++) begin
            @(negedge clk);
            if (ok && (init_done !== 1'b1 || {cs_n, ras_n, cas_n, we_n} != NOP)) begin
                ok = 1'b0; t = k;
            end
        end
        chk(ok, "R6 done sticky", t, -1);
        // restart and check the request pulse timing (R7)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        while (!init_done) @(negedge clk);
        ok = 1'b1; t = -1;
        for (int k = 0; k <= 3 * per; k++) begin
            if (ok && refresh_req !== (k != 0 && k % per == 0)) begin
                ok = 1'b0; t = k;
            end
            @(negedge clk);
        end
        chk(ok, "R7 refresh pulse cycle", t, -1);
        chk(cke === 1'b1, "R9 cke held", cke, 1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        run(0, 0, 2, 0, 0, 0, 0, 0, 2);        // minimum gaps, shortest period
        run(15, 15, 3, 7, 3, 3, 1, 1, 40);     // largest gaps and geometry
        for (int i = 0; i < 3; i++)
            run($urandom_range(1, 15), $urandom_range(1, 15), $urandom_range(2, 3),
                $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(3, 40));
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule